// File: doc/BRIEF.md
# SD Data FIFO with Threshold Requests

This block is the word buffer between a 32-bit register port and the data engine of an SD card host. Sixteen 32-bit words pass through one data register. A direction bit in the configuration register decides which side fills the buffer. In the card-to-host direction the engine pushes words and software (or a DMA channel) pops them through the data register. In the host-to-card direction software pushes through the data register and the engine pops. The card serializer and the CRC16 logic are not part of this block. They appear as a word-level push/pop stream with ready outputs.

The fill level can be read in a debug register. That register also holds two 5-bit thresholds, one for each direction, which decide when the DMA request line is raised. A shared data flag in the status register reports "data available" when reading and "space available" when writing. This flag can raise the interrupt only when its enable bit is set. A byte-count register and a 9-bit block-count register frame the engine-side traffic into blocks. At the end of each block the block-count register decrements and a sticky block flag is set, which can also raise the interrupt.

Register map, by word index on `reg_addr`:
- 0: data.
- 1: status. Bit 0 is the data flag. Bit 3 is the FIFO fault and is cleared by writing 1. Bit 9 is block done and is cleared by writing 1.
- 2: configuration. Bit 4 enables the data interrupt. Bit 6 selects the direction: 1 = card-to-host, 0 = host-to-card. Bit 8 enables the block interrupt.
- 3: debug. Bits 8:4 hold the level (read-only). Bits 13:9 hold the write threshold. Bits 18:14 hold the read threshold.
- 4: block size in bytes.
- 5: blocks remaining.

Top module: `sd_data_fifo`

## Requirements
- R1: After reset the level is 0, both thresholds are 4 (debug reads 0x10800), the direction is host-to-card, status reads 0x1 and `irq` is low.
- R2: Words leave the FIFO in the order they entered. Up to 16 words are held, and the debug field at bits 8:4 gives the current count.
- R3: A push to a full FIFO or a pop from an empty one, from either side, sets status bit 3 and leaves the contents and level unchanged. A data-register read of an empty FIFO returns 0. Writing 1 to status bit 3 clears it.
- R4: In the card-to-host direction, `dma_req` is high exactly when the level is at or above the read threshold (debug bits 18:14).
- R5: In the host-to-card direction, `dma_req` is high exactly when the free space (16 minus level) is at or above the write threshold (debug bits 13:9).
- R6: Status bit 0 is high when the FIFO is not empty (card-to-host) or not full (host-to-card). It drives `irq` only while configuration bit 4 is set.
- R7: Each engine-side transfer that completes a block of (byte count / 4) words sets status bit 9 and decrements the block-count register. While configuration bit 8 is set, bit 9 raises `irq`. Writing 1 to status bit 9 clears it.
- R8: Words below the read threshold at the end of a card-to-host transfer leave `dma_req` low, and they can still be read through the data register.
- R9: Only the side selected by the direction moves data. In card-to-host mode, data-register writes are ignored. In host-to-card mode, data-register reads return 0 and do not pop. Engine pushes are accepted only in card-to-host mode and engine pops only in host-to-card mode. Ignored accesses do not set status bit 3.
- R10: When the block count is 0, engine transfers complete no further blocks. The count stays at 0 and status bit 9 stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops when addressing data) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address and state |
| eng_push | input | 1 | Engine pushes a received word |
| eng_wdata | input | 32 | Word from the engine |
| eng_push_rdy | output | 1 | Engine push will be accepted |
| eng_pop | input | 1 | Engine takes a word to transmit |
| eng_rdata | output | 32 | Head word offered to the engine |
| eng_pop_rdy | output | 1 | Engine pop will be accepted |
| dma_req | output | 1 | DMA request from level and thresholds |
| irq | output | 1 | Interrupt from the gated data flag or the block flag |

## Verification
`reg_rdata` and `eng_rdata` are combinational and are due in the same cycle as the read strobe. A push, pop or register write changes the level, the status bits and the block count at the next rising edge. `dma_req`, the data flag and `irq` follow from that new state with no further register stage. The bench therefore raises each strobe at a falling edge and samples read data 1 ns later, before the rising edge that acts on the access. It samples every state-dependent result at the falling edge after that rising edge. The threshold boundaries (level 12 against 13 for writes, 3 against 4 and 1 against 2 for reads) are checked on both sides of each crossing.

// File: rtl/sdf_pkg.sv
// Shared register indices and field positions for the SD data FIFO.
package sdf_pkg;
    typedef enum logic [2:0] {
        REG_DATA  = 3'd0,
        REG_STAT  = 3'd1,
        REG_CFG   = 3'd2,
        REG_DBG   = 3'd3,
        REG_BYTES = 3'd4,
        REG_BLKS  = 3'd5
    } reg_sel_e;

    localparam int ST_FLAG_BIT = 0;
    localparam int ST_ERR_BIT  = 3;
    localparam int ST_BLK_BIT  = 9;
    localparam int CF_DIRQ_BIT = 4;
    localparam int CF_DIR_BIT  = 6;
    localparam int CF_BIRQ_BIT = 8;
    localparam int DBG_LVL_LSB = 4;
    localparam int DBG_WTH_LSB = 9;
    localparam int DBG_RTH_LSB = 14;
    localparam int FIELD_W     = 5;
endpackage

// File: rtl/sdf_storage.sv
// Circular word buffer with one push and one pop port.
// Assumes: callers may request a push and a pop in the same cycle; a push
// into a full buffer or a pop from an empty one is refused and reported.
module sdf_storage #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              push_ok,
    output logic              pop_ok
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and keep the word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    p_level_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (level == $past(level)));
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (level == '0));
endmodule

// File: rtl/sdf_thresh.sv
// Derives the DMA request and the shared data flag from level and thresholds.
// Assumes: level never exceeds DEPTH; thresholds are unsigned counts.
module sdf_thresh #(
    parameter int DEPTH   = 16,
    parameter int LVL_W   = 5,
    parameter int FIELD_W = 5,
    localparam int CW     = ((LVL_W > FIELD_W) ? LVL_W : FIELD_W) + 1
) (
    input  logic               dir_rd,
    input  logic [LVL_W-1:0]   level,
    input  logic [FIELD_W-1:0] rd_thr,
    input  logic [FIELD_W-1:0] wr_thr,
    output logic               dma_req,
    output logic               data_flag
);
    logic [CW-1:0] lvl_x;
    logic [CW-1:0] free_x;

    assign lvl_x  = CW'(level);
    assign free_x = CW'(DEPTH) - lvl_x;

    // Compare the side that matters for the current direction.
    always_comb begin
        if (dir_rd) begin
            dma_req   = (lvl_x >= CW'(rd_thr));
            data_flag = (lvl_x != '0);
        end else begin
            dma_req   = (free_x >= CW'(wr_thr));
            data_flag = (free_x != '0);
        end
    end
endmodule

// File: rtl/sdf_framer.sv
// Counts engine-side words into blocks and decrements the block count.
// Assumes: block size is a byte count whose word count is bytes/4; a
// load of either count restarts the word count of the current block.
module sdf_framer #(
    parameter int BYTES_W = 11,
    parameter int BLKS_W  = 9,
    localparam int WCNT_W = BYTES_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bytes_ld,
    input  logic [BYTES_W-1:0] bytes_in,
    input  logic               blks_ld,
    input  logic [BLKS_W-1:0]  blks_in,
    input  logic               xfer,
    output logic [BYTES_W-1:0] bytes_q,
    output logic [BLKS_W-1:0]  blks_left,
    output logic               blk_done
);
    logic [WCNT_W-1:0] wcnt;
    logic [WCNT_W-1:0] wpb;
    logic              active;

    assign wpb      = bytes_q[BYTES_W-1:2];
    assign active   = (blks_left != '0);
    assign blk_done = xfer && active && (wpb != '0) && (wcnt == wpb - 1'b1);

    // Hold the counts and step through words of each block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_q   <= '0;
            blks_left <= '0;
            wcnt      <= '0;
        end else begin
            if (bytes_ld) bytes_q <= bytes_in;
            if (blks_ld)       blks_left <= blks_in;
            else if (blk_done) blks_left <= blks_left - 1'b1;
            if (bytes_ld || blks_ld || blk_done) wcnt <= '0;
            else if (xfer && active)             wcnt <= wcnt + 1'b1;
        end
    end

    p_blk_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && !blks_ld) |=> (blks_left == $past(blks_left) - BLKS_W'(1)));
    p_wcnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wpb != '0) |-> (wcnt < wpb));
    p_blk_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (blks_left == '0 && !blks_ld) |=> (blks_left == '0));
endmodule

// File: rtl/sd_data_fifo.sv
// SD data FIFO: register decode, direction steering, status/config state,
// and the interrupt. Assumes a single register access per cycle.
module sd_data_fifo
    import sdf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 16,
    parameter int BYTES_W = 11,
    parameter int BLKS_W  = 9,
    parameter int THR_RST = 4,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_push,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic              eng_push_rdy,
    input  logic              eng_pop,
    output logic [DATA_W-1:0] eng_rdata,
    output logic              eng_pop_rdy,
    output logic              dma_req,
    output logic              irq
);
    logic               cfg_dirq, cfg_dir_rd, cfg_birq;
    logic [FIELD_W-1:0] rd_thr, wr_thr;
    logic               st_err, st_blk;
    logic               push, pop, push_ok, pop_ok, full, empty;
    logic [DATA_W-1:0]  push_data, head;
    logic [LVL_W-1:0]   level;
    logic               data_flag, xfer, blk_done, fault;
    logic [BYTES_W-1:0] bytes_q;
    logic [BLKS_W-1:0]  blks_left;
    logic               data_wr, data_rd, stat_wr;

    assign data_wr = reg_wr && (reg_addr == REG_DATA);
    assign data_rd = reg_rd && (reg_addr == REG_DATA);
    assign stat_wr = reg_wr && (reg_addr == REG_STAT);

    // Steer the single push and pop source by direction.
    assign push      = cfg_dir_rd ? eng_push  : data_wr;
    assign push_data = cfg_dir_rd ? eng_wdata : reg_wdata;
    assign pop       = cfg_dir_rd ? data_rd   : eng_pop;
    assign xfer      = cfg_dir_rd ? push_ok   : pop_ok;
    assign fault     = (push && !push_ok) || (pop && !pop_ok);

    assign eng_push_rdy = cfg_dir_rd && !full;
    assign eng_pop_rdy  = !cfg_dir_rd && !empty;
    assign eng_rdata    = head;
    assign irq          = (data_flag && cfg_dirq) || (st_blk && cfg_birq);

    sdf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .head(head), .level(level), .full(full), .empty(empty),
        .push_ok(push_ok), .pop_ok(pop_ok)
    );

    sdf_thresh #(.DEPTH(DEPTH), .LVL_W(LVL_W), .FIELD_W(FIELD_W)) u_thr (
        .dir_rd(cfg_dir_rd), .level(level), .rd_thr(rd_thr), .wr_thr(wr_thr),
        .dma_req(dma_req), .data_flag(data_flag)
    );

    sdf_framer #(.BYTES_W(BYTES_W), .BLKS_W(BLKS_W)) u_frm (
        .clk(clk), .rst_n(rst_n),
        .bytes_ld(reg_wr && (reg_addr == REG_BYTES)), .bytes_in(reg_wdata[BYTES_W-1:0]),
        .blks_ld(reg_wr && (reg_addr == REG_BLKS)), .blks_in(reg_wdata[BLKS_W-1:0]),
        .xfer(xfer), .bytes_q(bytes_q), .blks_left(blks_left), .blk_done(blk_done)
    );

    // Configuration and threshold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_dirq   <= 1'b0;
            cfg_dir_rd <= 1'b0;
            cfg_birq   <= 1'b0;
            rd_thr     <= FIELD_W'(THR_RST);
            wr_thr     <= FIELD_W'(THR_RST);
        end else begin
            if (reg_wr && (reg_addr == REG_CFG)) begin
                cfg_dirq   <= reg_wdata[CF_DIRQ_BIT];
                cfg_dir_rd <= reg_wdata[CF_DIR_BIT];
                cfg_birq   <= reg_wdata[CF_BIRQ_BIT];
            end
            if (reg_wr && (reg_addr == REG_DBG)) begin
                rd_thr <= reg_wdata[DBG_RTH_LSB +: FIELD_W];
                wr_thr <= reg_wdata[DBG_WTH_LSB +: FIELD_W];
            end
        end
    end

    // Sticky status flags: set by events, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_err <= 1'b0;
            st_blk <= 1'b0;
        end else begin
            if (fault)                               st_err <= 1'b1;
            else if (stat_wr && reg_wdata[ST_ERR_BIT]) st_err <= 1'b0;
            if (blk_done)                            st_blk <= 1'b1;
            else if (stat_wr && reg_wdata[ST_BLK_BIT]) st_blk <= 1'b0;
        end
    end

    // Register read mux; the data register yields 0 when nothing is poppable.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_DATA:  reg_rdata = (cfg_dir_rd && !empty) ? head : '0;
            REG_STAT: begin
                reg_rdata[ST_FLAG_BIT] = data_flag;
                reg_rdata[ST_ERR_BIT]  = st_err;
                reg_rdata[ST_BLK_BIT]  = st_blk;
            end
            REG_CFG: begin
                reg_rdata[CF_DIRQ_BIT] = cfg_dirq;
                reg_rdata[CF_DIR_BIT]  = cfg_dir_rd;
                reg_rdata[CF_BIRQ_BIT] = cfg_birq;
            end
            REG_DBG: begin
                reg_rdata[DBG_LVL_LSB +: FIELD_W] = FIELD_W'(level);
                reg_rdata[DBG_WTH_LSB +: FIELD_W] = wr_thr;
                reg_rdata[DBG_RTH_LSB +: FIELD_W] = rd_thr;
            end
            REG_BYTES: reg_rdata[BYTES_W-1:0] = bytes_q;
            REG_BLKS:  reg_rdata[BLKS_W-1:0]  = blks_left;
            default:   reg_rdata = '0;
        endcase
    end

    p_dma_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir_rd && rd_thr != '0 && dma_req) |-> !empty);
    p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cfg_dirq || cfg_birq));
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_err && !(stat_wr && reg_wdata[ST_ERR_BIT])) |=> st_err);
    p_blk_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && cfg_birq && !(reg_wr && reg_addr == REG_CFG)) |=> irq);
endmodule

// File: tb/sd_data_fifo_test.sv
`timescale 1ns/1ps
module sd_data_fifo_test;
    localparam logic [2:0] A_DATA = 3'd0, A_STAT = 3'd1, A_CFG = 3'd2,
                           A_DBG = 3'd3, A_BYTES = 3'd4, A_BLKS = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        eng_push = 1'b0, eng_pop = 1'b0;
    logic [31:0] eng_wdata = '0, eng_rdata;
    logic        eng_push_rdy, eng_pop_rdy, dma_req, irq;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    sd_data_fifo uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_push_rdy(eng_push_rdy),
        .eng_pop(eng_pop), .eng_rdata(eng_rdata), .eng_pop_rdy(eng_pop_rdy),
        .dma_req(dma_req), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
        #1;
    endtask

    task automatic epush(input logic [31:0] d);
        @(negedge clk); eng_push = 1'b1; eng_wdata = d;
        @(negedge clk); eng_push = 1'b0;
        #1;
    endtask

    task automatic epop(output logic [31:0] d);
        @(negedge clk); eng_pop = 1'b1;
        #1 d = eng_rdata;
        @(negedge clk); eng_pop = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_STAT, v); chk("R1 status", v, 32'h1);
        rd(A_DBG, v);  chk("R1 debug", v, 32'h0001_0800);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R5 dma at reset write dir", {31'b0, dma_req}, 32'h1);
    endtask

    task automatic t_write_fill;
        logic [31:0] v;
        for (int i = 0; i < 16; i++) begin
            wr(A_DATA, 32'hA000_0000 + i);
            if (i == 11) chk("R5 dma free=4", {31'b0, dma_req}, 32'h1);
            if (i == 12) chk("R5 dma free=3", {31'b0, dma_req}, 32'h0);
        end
        rd(A_DBG, v);  chk("R2 level 16", v, 32'h0001_0900);
        rd(A_STAT, v); chk("R6 flag full", v, 32'h0);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        wr(A_DATA, 32'hDEAD_BEEF);
        rd(A_STAT, v); chk("R3 overflow err", v, 32'h8);
        rd(A_DBG, v);  chk("R3 level kept", v, 32'h0001_0900);
        wr(A_STAT, 32'h8);
        rd(A_STAT, v); chk("R3 err cleared", v, 32'h0);
    endtask

    task automatic t_blocks;
        logic [31:0] v;
        wr(A_BYTES, 32'd16);
        wr(A_BLKS, 32'd2);
        wr(A_CFG, 32'h100);
        for (int j = 0; j < 16; j++) begin
            epop(v); chk("R2 order", v, 32'hA000_0000 + j);
            if (j == 3 || j == 7) begin
                chk("R7 block irq", {31'b0, irq}, 32'h1);
                rd(A_STAT, v); chk("R7 block flag", v, 32'h201);
                rd(A_BLKS, v); chk("R7 blocks left", v, (j == 3) ? 32'd1 : 32'd0);
                wr(A_STAT, 32'h200);
                chk("R7 irq cleared", {31'b0, irq}, 32'h0);
            end
        end
        rd(A_STAT, v); chk("R10 no block at zero", v, 32'h1);
        rd(A_BLKS, v); chk("R10 count stays 0", v, 32'd0);
        chk("R2 pop ready empty", {31'b0, eng_pop_rdy}, 32'h0);
    endtask

    task automatic t_read_tail;
        logic [31:0] v;
        wr(A_CFG, 32'h50);
        rd(A_STAT, v); chk("R6 empty flag", v, 32'h0);
        chk("R6 irq empty", {31'b0, irq}, 32'h0);
        for (int k = 0; k < 3; k++) epush(32'hB000_0000 + k);
        chk("R4 dma level 3", {31'b0, dma_req}, 32'h0);
        chk("R6 irq data", {31'b0, irq}, 32'h1);
        epush(32'hB000_0003);
        chk("R4 dma level 4", {31'b0, dma_req}, 32'h1);
        epush(32'hB000_0004);
        rd(A_DATA, v); chk("R2 read 0", v, 32'hB000_0000);
        rd(A_DATA, v); chk("R2 read 1", v, 32'hB000_0001);
        chk("R8 tail no dma", {31'b0, dma_req}, 32'h0);
        for (int k = 2; k < 5; k++) begin
            rd(A_DATA, v); chk("R8 tail read", v, 32'hB000_0000 + k);
        end
        rd(A_DATA, v); chk("R3 empty read 0", v, 32'h0);
        rd(A_STAT, v); chk("R3 underflow err", v, 32'h8);
        wr(A_STAT, 32'h8);
    endtask

    task automatic t_threshold;
        logic [31:0] v;
        wr(A_DBG, 32'h0000_8800);
        epush(32'hC000_0000);
        chk("R4 rthr2 level1", {31'b0, dma_req}, 32'h0);
        epush(32'hC000_0001);
        chk("R4 rthr2 level2", {31'b0, dma_req}, 32'h1);
        rd(A_DBG, v); chk("R4 debug fields", v, 32'h0000_8820);
    endtask

    task automatic t_dir_gate;
        logic [31:0] v;
        wr(A_DATA, 32'h1234_5678);
        rd(A_DBG, v);  chk("R9 reg write ignored", v, 32'h0000_8820);
        rd(A_STAT, v); chk("R9 no err", v, 32'h1);
        wr(A_CFG, 32'h0);
        rd(A_DATA, v); chk("R9 read ignored", v, 32'h0);
        epush(32'hEEEE_0000);
        rd(A_DBG, v);  chk("R9 level kept", v, 32'h0000_8820);
        rd(A_STAT, v); chk("R9 status clean", v, 32'h1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_write_fill();
        t_overflow();
        t_blocks();
        t_read_tail();
        t_threshold();
        t_dir_gate();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule